// File: doc/BRIEF.md
# Nested Interrupt Priority Resolver

This block is the decision core of an eight-input interrupt controller. It captures request lines into a pending register and holds a mask register and an in-service register. It raises a single interrupt line toward the processor whenever an enabled pending request ranks above every level currently being serviced. When the processor acknowledges, the block moves the winning level from pending to in-service and reports which level won.

End-of-interrupt and priority commands arrive as a 3-bit code plus a 3-bit level. They clear in-service bits either by rank or by name. They can also rotate the priority ring so that a chosen level becomes the lowest.

Three mode inputs adjust the behaviour:
- The trigger mode chooses between edge capture and level following.
- The automatic end-of-interrupt mode retires a level at the end of its acknowledge sequence.
- The special mask mode lets masked in-service levels stop blocking lower requests.

Vector generation and cascading are handled outside the block.

Top module: `irq_nest_core`

## Requirements
- R1: After reset the pending, in-service and mask registers are all zero. `int_o` is low, the rotate-on-auto-EOI flag is off, and `lowest_o` is 7, so level 0 ranks highest.
- R2: With `level_mode_i` low, a pending bit is set on a 0-to-1 transition of its input. It stays set after the input falls, and it is cleared when that level is granted. An input that is held high after its grant does not request again.
- R3: With `level_mode_i` high, each pending bit equals its input as sampled at the previous clock edge.
- R4: A mask bit of 1 keeps its level from raising `int_o` and from being granted, although the pending bit still records the request. A mask write takes effect from the next cycle.
- R5: `int_o` is high exactly when the highest-ranked unmasked pending level ranks strictly above every in-service level under the current rotation. A request of equal or lower rank waits.
- R6: An `ack_i` pulse while `int_o` is high sets the in-service bit of the winning level. The same edge loads that level into `ack_level_o`. An `ack_i` pulse while `int_o` is low changes nothing.
- R7: Command code 001 clears the highest-ranked in-service bit. Code 011 clears the in-service bit named by `cmd_level_i`.
- R8: Command code 110 makes `cmd_level_i` the lowest level. Codes 101 and 111 perform the EOI of 001 and 011 respectively, and then make the cleared level the lowest.
- R9: With `auto_eoi_i` high, an `ack_end_i` pulse clears the in-service bit of the last granted level. Code 100 sets a flag that also makes that level the lowest; code 000 clears the flag.
- R10: With `special_mask_i` high, in-service levels that are masked no longer hold off lower-ranked requests.
- R11: When a grant and an EOI fall on the same edge, the winner is chosen from the state before the command. If the EOI names the level being granted, the set wins; an EOI that hits another bit still takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 8 | Raw request lines |
| level_mode_i | input | 1 | 1 = level-following requests, 0 = edge capture |
| auto_eoi_i | input | 1 | Automatic end-of-interrupt enable |
| special_mask_i | input | 1 | Special mask mode enable |
| mask_we_i | input | 1 | Mask register write strobe |
| mask_wdata_i | input | 8 | New mask value, 1 = blocked |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_code_i | input | 3 | Rotate/select/EOI code |
| cmd_level_i | input | 3 | Level used by named commands |
| ack_i | input | 1 | Grant pulse (first acknowledge) |
| ack_end_i | input | 1 | End of the last acknowledge pulse |
| int_o | output | 1 | Interrupt request to the processor |
| ack_level_o | output | 3 | Level granted by the latest acknowledge |
| irr_o | output | 8 | Pending request register |
| isr_o | output | 8 | In-service register |
| imr_o | output | 8 | Mask register |
| lowest_o | output | 3 | Level currently ranked lowest |

## Verification
The grant and the EOI command can both act on the in-service register in the same cycle. The bench provokes this by pulsing `ack_i` together with a named EOI for the very level being granted. It then pulses `ack_i` together with a rank-based EOI that targets an older in-service level. In the first case the granted bit must remain set; in the second case the older bit must disappear while the new one appears. Each case is judged from `isr_o` and `ack_level_o` one cycle later.

// File: rtl/irq_nest_pkg.sv
package irq_nest_pkg;
  // Command codes, bit order {rotate, select, eoi}
  typedef enum logic [2:0] {
    CMD_ROTA_CLR    = 3'b000,
    CMD_EOI_TOP     = 3'b001,
    CMD_NOP         = 3'b010,
    CMD_EOI_NAMED   = 3'b011,
    CMD_ROTA_SET    = 3'b100,
    CMD_ROT_EOI_TOP = 3'b101,
    CMD_SET_LOWEST  = 3'b110,
    CMD_ROT_EOI_NAM = 3'b111
  } cmd_e;
endpackage

// File: rtl/irq_req_capture.sv
module irq_req_capture #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req_i,
  input  logic         level_mode_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] irr_o
);
  logic [N-1:0] req_q, irr_q, rise;

  assign rise  = req_i & ~req_q;
  assign irr_o = irr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q <= '0;
      irr_q <= '0;
    end else begin
      req_q <= req_i;
      irr_q <= level_mode_i ? req_i : ((irr_q | rise) & ~clr_i);
    end
  end

  // R2
  edge_latch_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(level_mode_i) |-> ((irr_q & ~$past(irr_q) & ~$past(rise)) == '0));
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int N  = 8,
  parameter int LW = $clog2(N)
) (
  input  logic [N-1:0]  vec_i,
  input  logic [LW-1:0] low_i,
  output logic          found_o,
  output logic [LW-1:0] lvl_o
);
  // Scan from the level just above the lowest, wrapping round the ring
  function automatic logic [LW:0] pick(input logic [N-1:0] v, input logic [LW-1:0] low);
    logic [LW-1:0] idx;
    logic          f;
    logic [LW-1:0] l;
    f = 1'b0;
    l = '0;
    for (int k = N - 1; k >= 0; k--) begin
      idx = low + LW'(k + 1);
      if (v[idx]) begin
        f = 1'b1;
        l = idx;
      end
    end
    return {f, l};
  endfunction

  assign {found_o, lvl_o} = pick(vec_i, low_i);
endmodule

// File: rtl/irq_nest_core.sv
module irq_nest_core #(
  parameter int N  = 8,
  parameter int LW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req_i,
  input  logic          level_mode_i,
  input  logic          auto_eoi_i,
  input  logic          special_mask_i,
  input  logic          mask_we_i,
  input  logic [N-1:0]  mask_wdata_i,
  input  logic          cmd_valid_i,
  input  logic [2:0]    cmd_code_i,
  input  logic [LW-1:0] cmd_level_i,
  input  logic          ack_i,
  input  logic          ack_end_i,
  output logic          int_o,
  output logic [LW-1:0] ack_level_o,
  output logic [N-1:0]  irr_o,
  output logic [N-1:0]  isr_o,
  output logic [N-1:0]  imr_o,
  output logic [LW-1:0] lowest_o
);
  import irq_nest_pkg::*;

  localparam logic [N-1:0] ONE = {{(N-1){1'b0}}, 1'b1};

  logic [N-1:0]  imr_q, isr_q, irr, pend, ceil_vec, set_vec, eoi_clr, aeoi_clr;
  logic [LW-1:0] low_q, low_d, ack_lvl_q, p_lvl, c_lvl, e_lvl;
  logic          rot_aeoi_q, aeoi_armed_q, p_found, c_found, e_found;
  logic          int_w, ack_take, aeoi_fire;
  cmd_e          cmd;

  // Rank 0 is the highest; the lowest level has rank N-1
  function automatic logic [LW-1:0] rank_of(input logic [LW-1:0] lvl, input logic [LW-1:0] low);
    return lvl - low - LW'(1);
  endfunction

  irq_req_capture #(.N(N)) u_cap (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .level_mode_i(level_mode_i),
    .clr_i(set_vec), .irr_o(irr)
  );

  assign pend     = irr & ~imr_q;
  assign ceil_vec = special_mask_i ? (isr_q & ~imr_q) : isr_q;

  irq_prio_pick #(.N(N), .LW(LW)) u_pick_req (
    .vec_i(pend), .low_i(low_q), .found_o(p_found), .lvl_o(p_lvl));
  irq_prio_pick #(.N(N), .LW(LW)) u_pick_ceil (
    .vec_i(ceil_vec), .low_i(low_q), .found_o(c_found), .lvl_o(c_lvl));
  irq_prio_pick #(.N(N), .LW(LW)) u_pick_eoi (
    .vec_i(isr_q), .low_i(low_q), .found_o(e_found), .lvl_o(e_lvl));

  assign int_w     = p_found && (!c_found || (rank_of(p_lvl, low_q) < rank_of(c_lvl, low_q)));
  assign ack_take  = ack_i && int_w;
  assign set_vec   = ack_take ? (ONE << p_lvl) : '0;
  assign aeoi_fire = ack_end_i && auto_eoi_i && aeoi_armed_q;
  assign aeoi_clr  = aeoi_fire ? (ONE << ack_lvl_q) : '0;
  assign cmd       = cmd_e'(cmd_code_i);

  always_comb begin
    eoi_clr = '0;
    low_d   = low_q;
    if (aeoi_fire && rot_aeoi_q) low_d = ack_lvl_q;
    if (cmd_valid_i) begin
      case (cmd)
        CMD_EOI_TOP:     if (e_found) eoi_clr = ONE << e_lvl;
        CMD_EOI_NAMED:   eoi_clr = ONE << cmd_level_i;
        CMD_ROT_EOI_TOP: if (e_found) begin
                           eoi_clr = ONE << e_lvl;
                           low_d   = e_lvl;
                         end
        CMD_ROT_EOI_NAM: begin
                           eoi_clr = ONE << cmd_level_i;
                           low_d   = cmd_level_i;
                         end
        CMD_SET_LOWEST:  low_d = cmd_level_i;
        default:         ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      imr_q        <= '0;
      isr_q        <= '0;
      low_q        <= LW'(N - 1);
      ack_lvl_q    <= '0;
      rot_aeoi_q   <= 1'b0;
      aeoi_armed_q <= 1'b0;
    end else begin
      if (mask_we_i) imr_q <= mask_wdata_i;
      isr_q <= (isr_q & ~eoi_clr & ~aeoi_clr) | set_vec;
      low_q <= low_d;
      if (ack_take) ack_lvl_q <= p_lvl;
      if (ack_take) aeoi_armed_q <= 1'b1;
      else if (ack_end_i) aeoi_armed_q <= 1'b0;
      if (cmd_valid_i && cmd == CMD_ROTA_SET) rot_aeoi_q <= 1'b1;
      if (cmd_valid_i && cmd == CMD_ROTA_CLR) rot_aeoi_q <= 1'b0;
    end
  end

  assign int_o       = int_w;
  assign ack_level_o = ack_lvl_q;
  assign irr_o       = irr;
  assign isr_o       = isr_q;
  assign imr_o       = imr_q;
  assign lowest_o    = low_q;

  // R5
  int_needs_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int_o |-> (|(irr & ~imr_q)));
  // R6
  isr_set_on_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((isr_q & ~$past(isr_q)) != '0) |-> $past(ack_i));
  // R6
  isr_one_per_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(isr_q & ~$past(isr_q)) <= 1);
  // R4
  masked_never_granted_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_take |-> !imr_q[p_lvl]);
  // R8
  lowest_moves_on_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(low_q) |-> $past(cmd_valid_i || ack_end_i));
endmodule

// File: tb/irq_nest_core_tb.sv
module irq_nest_core_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] req = '0, mask_wdata = '0;
  logic       level_mode = 0, auto_eoi = 0, smm = 0, mask_we = 0;
  logic       cmd_valid = 0, ack = 0, ack_end = 0;
  logic [2:0] cmd_code = '0, cmd_level = '0;
  logic       int_o;
  logic [2:0] ack_level, lowest;
  logic [7:0] irr, isr, imr;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  irq_nest_core u_dut (
    .clk(clk), .rst_n(rst_n), .req_i(req), .level_mode_i(level_mode),
    .auto_eoi_i(auto_eoi), .special_mask_i(smm), .mask_we_i(mask_we),
    .mask_wdata_i(mask_wdata), .cmd_valid_i(cmd_valid), .cmd_code_i(cmd_code),
    .cmd_level_i(cmd_level), .ack_i(ack), .ack_end_i(ack_end), .int_o(int_o),
    .ack_level_o(ack_level), .irr_o(irr), .isr_o(isr), .imr_o(imr), .lowest_o(lowest)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step(); @(negedge clk); endtask

  task automatic do_reset();
    req = '0; level_mode = 0; auto_eoi = 0; smm = 0; mask_we = 0;
    cmd_valid = 0; ack = 0; ack_end = 0;
    rst_n = 0; step(); step(); rst_n = 1; step();
  endtask

  task automatic raise(input int b); req[b] = 1'b1; step(); endtask
  task automatic do_ack(); ack = 1; step(); ack = 0; endtask
  task automatic do_end(); ack_end = 1; step(); ack_end = 0; endtask
  task automatic do_cmd(input logic [2:0] c, input logic [2:0] l);
    cmd_valid = 1; cmd_code = c; cmd_level = l; step(); cmd_valid = 0;
  endtask
  task automatic do_mask(input logic [7:0] m);
    mask_we = 1; mask_wdata = m; step(); mask_we = 0;
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 irr", irr, 0); check("R1 isr", isr, 0); check("R1 imr", imr, 0);
    check("R1 int", int_o, 0); check("R1 lowest", lowest, 7);
  endtask

  task automatic t_edge_level();
    do_reset();
    raise(6); req[6] = 0; step();
    check("R2 edge latch held", irr, 8'h40);
    do_ack();
    check("R2 cleared on grant", irr, 0);
    raise(3); do_ack(); step();
    check("R2 held high no rerequest", irr, 0);
    do_reset(); level_mode = 1;
    raise(6);
    check("R3 level follow high", irr, 8'h40);
    req[6] = 0; step();
    check("R3 level follow low", irr, 0);
  endtask

  task automatic t_mask();
    do_reset();
    do_mask(8'h04);
    raise(2);
    check("R4 masked still pending", irr, 8'h04);
    check("R4 masked no int", int_o, 0);
    do_ack();
    check("R6 ack without int ignored", isr, 0);
    do_mask(8'h00);
    check("R4 unmask raises int", int_o, 1);
  endtask

  task automatic t_nest();
    do_reset();
    raise(3); do_ack();
    check("R6 grant isr", isr, 8'h08); check("R6 grant level", ack_level, 3);
    raise(5);
    check("R5 lower waits", int_o, 0);
    raise(1);
    check("R5 higher interrupts", int_o, 1);
    do_ack();
    check("R6 nested isr", isr, 8'h0A); check("R6 nested level", ack_level, 1);
    do_cmd(3'b001, 0);
    check("R7 eoi top", isr, 8'h08); check("R5 still blocked", int_o, 0);
    do_cmd(3'b001, 0);
    check("R7 eoi top again", isr, 0); check("R5 released", int_o, 1);
    do_ack();
    check("R6 grant 5", ack_level, 5);
    do_cmd(3'b011, 5);
    check("R7 eoi named", isr, 0);
  endtask

  task automatic t_rotate();
    do_reset();
    do_cmd(3'b110, 2);
    check("R8 set lowest", lowest, 2);
    req[1] = 1; req[4] = 1; step();
    do_ack();
    check("R8 rotated winner", ack_level, 4);
    check("R5 rank 6 waits", int_o, 0);
    do_cmd(3'b101, 0);
    check("R8 rot eoi top isr", isr, 0); check("R8 rot eoi top lowest", lowest, 4);
    do_ack();
    check("R8 next winner", ack_level, 1);
    do_cmd(3'b111, 1);
    check("R8 rot eoi named isr", isr, 0); check("R8 rot eoi named lowest", lowest, 1);
  endtask

  task automatic t_aeoi();
    do_reset(); auto_eoi = 1;
    raise(4); do_ack();
    check("R9 set before end", isr, 8'h10);
    do_end();
    check("R9 auto cleared", isr, 0); check("R9 no rotation", lowest, 7);
    do_cmd(3'b100, 0);
    raise(2); do_ack(); do_end();
    check("R9 rot auto cleared", isr, 0); check("R9 rot lowest", lowest, 2);
    do_cmd(3'b000, 0);
    raise(5); do_ack(); do_end();
    check("R9 rot flag off", lowest, 2);
  endtask

  task automatic t_smm();
    do_reset();
    raise(2); do_ack(); raise(5);
    do_mask(8'h04);
    check("R10 normal blocks", int_o, 0);
    smm = 1; step();
    check("R10 special passes", int_o, 1);
    do_ack();
    check("R10 grant under special", isr, 8'h24);
  endtask

  task automatic t_same_cycle();
    do_reset();
    raise(3); do_ack(); raise(1);
    ack = 1; cmd_valid = 1; cmd_code = 3'b011; cmd_level = 1; step();
    ack = 0; cmd_valid = 0;
    check("R11 set beats named eoi", isr, 8'h0A);
    do_cmd(3'b011, 1);
    raise(0);
    ack = 1; cmd_valid = 1; cmd_code = 3'b001; cmd_level = 0; step();
    ack = 0; cmd_valid = 0;
    check("R11 grant plus eoi top", isr, 8'h01);
    check("R11 winner level", ack_level, 0);
  endtask

  initial begin
    t_reset();
    t_edge_level();
    t_mask();
    t_nest();
    t_rotate();
    t_aeoi();
    t_smm();
    t_same_cycle();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule